// File: doc/BRIEF.md
# Wrapping Burst Read Address Sequencer

This block produces the word address for a synchronous 32-word burst read out of a memory array. A strobe captures a starting address. From then on, each clock edge on which the advance input is low steps the presented word forward by one. The low address bits wrap modulo 32 around the start, so the sequence comes back to the starting word and not to an aligned boundary. The bits above the burst window stay fixed for the whole burst.

An active-low end-of-burst flag is driven low while the 32nd word of the burst (start plus 31) is being presented. A valid flag shows that a starting address has been captured since reset. The memory array, the output drivers and the analog timing sit outside this block.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_ni is low, and right after it is released, valid_o is 0, last_no is 1 and addr_o is 0. Asserting rst_ni in the middle of a burst applies this state at once, without waiting for a clock edge.
- R2: Consider a rising clock edge with load_ni low. After that edge, valid_o is 1, addr_o equals the start_addr_i sampled at that edge, and last_no is 1. The internal burst position is reset to 0.
- R3: Consider a rising edge with valid_o at 1, load_ni high and adv_ni low. The edge advances the position n by one, modulo 32. The address is then shown as addr_o[4:0] = (start[4:0] + n) mod 32, with addr_o[ADDR_W-1:5] = start[ADDR_W-1:5].
- R4: last_no is 0 exactly when valid_o is 1 and the position is 31, which is the 32nd word. In every other case it is 1.
- R5: One advance from the 32nd word presents the starting address again, at position 0, and last_no returns to 1.
- R6: A rising edge with load_ni high and adv_ni high leaves addr_o, last_no and valid_o unchanged.
- R7: When load_ni and adv_ni are both low at the same edge, the load wins, and the starting word is presented at position 0.
- R8: Before the first load after reset, adv_ni has no effect: valid_o stays 0 and addr_o stays 0.
- R9: A load during a burst restarts the sequence from the newly captured start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_ni | input | 1 | Capture start_addr_i, active low |
| start_addr_i | input | ADDR_W | Starting word address |
| adv_ni | input | 1 | Advance one word, active low |
| addr_o | output | ADDR_W | Current array word address |
| last_no | output | 1 | End of burst, low on the 32nd word |
| valid_o | output | 1 | A start address has been captured |

## Verification
The bench starts a burst from a start whose low bits are near the top of the window (0x1D). This catches a design that carries into the upper address bits, or that wraps to an aligned boundary instead of to the start. It walks all 32 words and checks that last_no falls on the 32nd word only, so an off-by-one flag would show up as an early or late strobe. It then advances once more and expects the start address back at position 0.

Several scenarios aim at the edge cases of the control inputs:
- Advances issued before any load, which a careless counter would let move.
- A load on the same edge as an advance, which a wrong priority would turn into start plus 1.
- Held cycles, where last_no must keep its level.
- A reset asserted in the middle of a burst.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  localparam int unsigned DEF_ADDR_W    = 19;
  localparam int unsigned DEF_BURST_LEN = 32;
endpackage

// File: rtl/bseq_counter.sv
module bseq_counter #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_ni,
  input  logic             adv_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             valid_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             valid_q;
  logic             step;

  // a load masks any advance on the same edge
  assign step = valid_q && load_ni && !adv_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else if (!load_ni) begin
      cnt_q   <= '0;
      valid_q <= 1'b1;
    end else if (step) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o   = cnt_q;
  assign valid_o = valid_q;

  AST_LOAD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ni |=> (cnt_q == '0) && valid_q); // R2
  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && load_ni && !adv_ni) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1)); // R3
  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && load_ni && !adv_ni && cnt_q == CNT_MAX) |=> cnt_q == '0); // R5
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && adv_ni) |=> $stable(cnt_q) && $stable(valid_q)); // R6
  AST_IDLE_NO_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_q && load_ni) |=> !valid_q && cnt_q == '0); // R8
endmodule

// File: rtl/bseq_addr_gen.sv
module bseq_addr_gen #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned CNT_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_ni,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              valid_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_no
);
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  low_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       base_q <= '0;
    else if (!load_ni) base_q <= start_addr_i;
  end

  // offset inside the burst window, wraps modulo the burst length
  assign low_w   = base_q[CNT_W-1:0] + cnt_i;
  assign addr_o  = {base_q[ADDR_W-1:CNT_W], low_w};
  assign last_no = !(valid_i && (&cnt_i));

  AST_UPPER_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_ni |=> $stable(addr_o[ADDR_W-1:CNT_W])); // R3
  AST_LAST_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_no |-> valid_i); // R4
  AST_LAST_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_no |-> addr_o[CNT_W-1:0] == CNT_W'(base_q[CNT_W-1:0] - 1'b1)); // R4
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int unsigned ADDR_W    = bseq_pkg::DEF_ADDR_W,
  parameter int unsigned BURST_LEN = bseq_pkg::DEF_BURST_LEN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_ni,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              adv_ni,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_no,
  output logic              valid_o
);
  localparam int unsigned CNT_W = $clog2(BURST_LEN);

  logic [CNT_W-1:0] cnt_w;
  logic             valid_w;

  bseq_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_ni (load_ni),
    .adv_ni  (adv_ni),
    .cnt_o   (cnt_w),
    .valid_o (valid_w)
  );

  bseq_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_addr_gen (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_ni      (load_ni),
    .start_addr_i (start_addr_i),
    .cnt_i        (cnt_w),
    .valid_i      (valid_w),
    .addr_o       (addr_o),
    .last_no      (last_no)
  );

  assign valid_o = valid_w;

  AST_LOAD_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ni |=> (addr_o == $past(start_addr_i)) && last_no && valid_o); // R7
  AST_LAST_THEN_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!last_no && load_ni && !adv_ni) |=> last_no); // R5
  AST_RESET_STATE: assert property (@(posedge clk_i)
    !rst_ni |-> !valid_o && last_no && addr_o == '0); // R1
endmodule

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
  localparam int unsigned AW = 19;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          load_ni = 1'b1;
  logic          adv_ni = 1'b1;
  logic [AW-1:0] start_addr = '0;
  logic [AW-1:0] addr_o;
  logic          last_no, valid_o;

  int checks = 0;
  int failures = 0;

  // expectations built from the requirements
  logic [AW-1:0] m_base = '0;
  logic [4:0]    m_pos = '0;
  logic          m_valid = 1'b0;

  always #5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BURST_LEN(32)) i_burst_addr_seq (
    .clk_i(clk), .rst_ni(rst_ni), .load_ni(load_ni), .start_addr_i(start_addr),
    .adv_ni(adv_ni), .addr_o(addr_o), .last_no(last_no), .valid_o(valid_o)
  );

  function automatic logic [AW-1:0] exp_addr();
    logic [4:0] lo;
    lo = m_base[4:0] + m_pos;
    return {m_base[AW-1:5], lo};
  endfunction

  task automatic check(input string tag);
    logic [AW-1:0] ea;
    logic          el;
    ea = exp_addr();
    el = !(m_valid && m_pos == 5'd31);
    checks++;
    if (addr_o !== ea || last_no !== el || valid_o !== m_valid) begin
      failures++;
      $display("FAIL %s: addr=%h last_n=%b valid=%b expected addr=%h last_n=%b valid=%b",
               tag, addr_o, last_no, valid_o, ea, el, m_valid);
    end
  endtask

  // one clock: drive at negedge, update expectation at the edge, sample after it
  task automatic step(input logic ld, input logic adv, input logic [AW-1:0] a,
                      input string tag);
    @(negedge clk);
    load_ni = !ld; adv_ni = !adv; start_addr = a;
    @(posedge clk);
    if (ld) begin m_base = a; m_pos = '0; m_valid = 1'b1; end
    else if (m_valid && adv) m_pos = m_pos + 5'd1;
    #1;
    check(tag);
  endtask

  task automatic t_reset();
    check("R1 reset state");
    @(negedge clk); rst_ni = 1'b1;
    @(posedge clk); #1;
    check("R1 after release");
  endtask

  task automatic t_adv_before_load();
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 19'h7ffff, "R8 adv before load");
  endtask

  task automatic t_full_burst(input logic [AW-1:0] a);
    step(1'b1, 1'b0, a, "R2 load start");
    for (int i = 1; i < 32; i++) begin
      if (i == 31) step(1'b0, 1'b1, '0, "R4 32nd word");
      else         step(1'b0, 1'b1, '0, "R3 advance");
    end
    step(1'b0, 1'b1, '0, "R5 wrap to start");
    step(1'b0, 1'b1, '0, "R3 after wrap");
  endtask

  task automatic t_hold();
    step(1'b1, 1'b0, 19'h00a40, "R2 load for hold");
    for (int i = 0; i < 30; i++) step(1'b0, 1'b1, '0, "R3 walk");
    step(1'b0, 1'b1, '0, "R4 last before hold");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 19'h12345, "R6 hold at last");
    step(1'b0, 1'b1, '0, "R5 wrap after hold");
    step(1'b0, 1'b0, '0, "R6 hold mid");
  endtask

  task automatic t_load_priority();
    step(1'b0, 1'b1, '0, "R3 pre");
    step(1'b1, 1'b1, 19'h3001f, "R7 load with advance");
    step(1'b0, 1'b1, '0, "R7 next is start+1");
  endtask

  task automatic t_reload();
    step(1'b1, 1'b0, 19'h01234, "R9 first load");
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, '0, "R9 partial");
    step(1'b1, 1'b0, 19'h4567e, "R9 reload");
    step(1'b0, 1'b1, '0, "R9 after reload");
    step(1'b0, 1'b1, '0, "R9 after reload 2");
  endtask

  task automatic t_mid_reset();
    @(negedge clk); rst_ni = 1'b0;
    m_base = '0; m_pos = '0; m_valid = 1'b0;
    #1; check("R1 async reset mid burst");
    @(negedge clk); rst_ni = 1'b1;
    step(1'b0, 1'b1, '0, "R8 adv after reset");
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog: run did not complete");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_adv_before_load();
    t_full_burst(19'h1235d);
    t_full_burst(19'h2a000);
    t_hold();
    t_load_priority();
    t_reload();
    t_mid_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule